// File: doc/BRIEF.md
# Lockable DRAM Top-of-Memory Decoder

This block holds the memory-map boundaries of a host memory controller and sorts every physical address it is given into one region. Configuration software programs a top boundary for DRAM below 4 GB, a top boundary for DRAM above 4 GB, and one control word. The control word carries a size code for the graphics data reserve and a size code for the translation-table reserve. Each of the three registers has its own lock bit. Once the lock bit is set, the whole register is frozen until reset, and that includes the lock bit itself.

The block stacks the two reserved regions directly under the low boundary. The graphics data region sits just below the low boundary, and the table region sits just below the data region. Both bases come from subtracting the decoded sizes, so software never programs them. A request address is registered first. The region code is then decoded combinationally from that registered address and the current configuration, and the result is returned one cycle after the request.

Top module: `dram_top_decoder`

## Requirements
- R1: After reset, the registers read as follows:
  - low boundary field = 0x001 (1 MB);
  - upper boundary field = 0;
  - data size code = 0x05;
  - table size code = 0;
  - all locks = 0;
  - error flag = 0.
- R2: For an address below 4 GB, the region is low DRAM (code 1) when address bits 31:20 are strictly below the low boundary. Otherwise the region is none (code 0). Bits 19:0 take no part in the comparison.
- R3: An address at or above 4 GB gives high DRAM (code 2) when address bits 38:20 are strictly below the upper boundary. Otherwise it gives none (code 0).
- R4: Setting bit 0 of the low-boundary register (word 0) or of the upper-boundary register (word 1) locks that register. After that, writes change none of its bits, including the lock.
- R5: The data size code sets the size of the graphics data region:
  - codes 0x00 to 0x10 give the code times 32 MB;
  - 0x20 gives 1024 MB;
  - 0x30 gives 1536 MB;
  - 0x3F gives 2016 MB.
- R6: The table size code selects the table region size: 0 gives 0 MB, 1 gives 2 MB, 2 gives 4 MB and 3 gives 8 MB.
- R7: The two region bases are derived as follows:
  - data base = low boundary − data size;
  - table base = data base − table size;
  - addresses in [data base, low boundary) give code 3, and this takes precedence over low DRAM;
  - addresses in [table base, data base) give code 4.
- R8: Setting bit 0 of the control register (word 2) freezes the data code, the table code and the lock bit.
- R9: A data size code that R5 does not list counts as 0 MB. It also sets an error flag, read at word 3 bit 0. The flag stays set until reset, even after the code is corrected.
- R10: Each request with `req_vld` high produces exactly one `rsp_vld` pulse on the following cycle. `rsp_vld` is low when no request was made.
- R11: Reads return the fields at these positions, and every other bit reads as 0:
  - word 0: low boundary at [31:20], lock at [0];
  - word 1: upper boundary at [31:13], lock at [0];
  - word 2: data code at [15:8], table code at [7:6], lock at [0];
  - word 3: error flag at [0].
- R12: With saturating bases, a size larger than the space below it clamps that base to 0 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register word index |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (combinational) |
| req_vld | input | 1 | Address request valid |
| req_pa | input | PA_W (39) | Physical address to classify |
| rsp_vld | output | 1 | Classification result valid |
| rsp_region | output | 3 | Region code: 0 none, 1 low, 2 high, 3 graphics data, 4 table |

## Verification
The bench builds the block with its defaults:
- a 39-bit physical address;
- a registered request stage;
- saturating base arithmetic.

These settings put 1 MB edges on both sides of 4 GB within reach, along with the top of the 39-bit space. The saturating setting lets a 2016 MB data reserve sit under a 256 MB boundary to exercise the clamp. The bench walks several data and table size codes and probes each derived base, one megabyte above and below it. It also checks that locked and reserved settings show at the ports in both the read data and the region codes.

// File: rtl/dtd_pkg.sv
package dtd_pkg;

   localparam int MB_LSB = 20;
   localparam int LOW_W  = 32 - MB_LSB;

   typedef enum logic [2:0] {
      RGN_NONE  = 3'd0,
      RGN_LOW   = 3'd1,
      RGN_HIGH  = 3'd2,
      RGN_GDATA = 3'd3,
      RGN_TABLE = 3'd4
   } region_e;

   function automatic logic data_code_rsvd(input logic [7:0] code);
      return !((code <= 8'h10) || (code == 8'h20) || (code == 8'h30) || (code == 8'h3F));
   endfunction

   function automatic logic [LOW_W-1:0] data_code_mb(input logic [7:0] code);
      logic [LOW_W-1:0] sz;
      if (code <= 8'h10)      sz = LOW_W'(code) << 5;
      else if (code == 8'h20) sz = LOW_W'(1024);
      else if (code == 8'h30) sz = LOW_W'(1536);
      else if (code == 8'h3F) sz = LOW_W'(2016);
      else                    sz = '0;
      return sz;
   endfunction

   function automatic logic [LOW_W-1:0] table_code_mb(input logic [1:0] code);
      logic [LOW_W-1:0] sz;
      case (code)
         2'd1:    sz = LOW_W'(2);
         2'd2:    sz = LOW_W'(4);
         2'd3:    sz = LOW_W'(8);
         default: sz = '0;
      endcase
      return sz;
   endfunction

endpackage

// File: rtl/dtd_cfg_regs.sv
module dtd_cfg_regs
   import dtd_pkg::*;
#(
   parameter int UP_W = 19
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       addr,
   input  logic [31:0]      wdata,
   output logic [31:0]      rdata,
   input  logic             cfg_err,
   output logic [LOW_W-1:0] low_top,
   output logic             low_lock,
   output logic [UP_W-1:0]  up_top,
   output logic             up_lock,
   output logic [7:0]       dcode,
   output logic [1:0]       tcode,
   output logic             g_lock
);
   localparam int          UP_LSB   = 32 - UP_W;
   localparam logic [1:0]  W_LOW    = 2'd0;
   localparam logic [1:0]  W_UP     = 2'd1;
   localparam logic [1:0]  W_GCTL   = 2'd2;
   localparam logic [1:0]  W_STAT   = 2'd3;
   localparam logic [7:0]  DCODE_RST = 8'h05;

   generate
      if (UP_W < 1 || UP_W > 31) begin : g_bad_up_w
         $error("dtd_cfg_regs: UP_W must lie in 1..31");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         low_top  <= LOW_W'(1);
         low_lock <= 1'b0;
         up_top   <= '0;
         up_lock  <= 1'b0;
         dcode    <= DCODE_RST;
         tcode    <= 2'd0;
         g_lock   <= 1'b0;
      end else if (wr_en) begin
         case (addr)
            W_LOW: if (!low_lock) begin
               low_top  <= wdata[31:MB_LSB];
               low_lock <= wdata[0];
            end
            W_UP: if (!up_lock) begin
               up_top  <= wdata[31:UP_LSB];
               up_lock <= wdata[0];
            end
            W_GCTL: if (!g_lock) begin
               dcode  <= wdata[15:8];
               tcode  <= wdata[7:6];
               g_lock <= wdata[0];
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         W_LOW:  begin rdata[31:MB_LSB] = low_top; rdata[0] = low_lock; end
         W_UP:   begin rdata[31:UP_LSB] = up_top;  rdata[0] = up_lock;  end
         W_GCTL: begin rdata[15:8] = dcode; rdata[7:6] = tcode; rdata[0] = g_lock; end
         W_STAT: rdata[0] = cfg_err;
         default: ;
      endcase
   end

   logic unused_wbits;
   assign unused_wbits = ^wdata;

endmodule

// File: rtl/dtd_base_calc.sv
module dtd_base_calc
   import dtd_pkg::*;
#(
   parameter bit SAT_BASE = 1'b1
) (
   input  logic [LOW_W-1:0] low_top,
   input  logic [7:0]       dcode,
   input  logic [1:0]       tcode,
   output logic [LOW_W-1:0] dbase,
   output logic [LOW_W-1:0] tbase,
   output logic             rsvd
);
   logic [LOW_W-1:0] d_sz, t_sz;
   logic [LOW_W:0]   d_diff, t_diff;

   assign rsvd   = data_code_rsvd(dcode);
   assign d_sz   = data_code_mb(dcode);
   assign t_sz   = table_code_mb(tcode);
   assign d_diff = {1'b0, low_top} - {1'b0, d_sz};
   assign t_diff = {1'b0, dbase} - {1'b0, t_sz};

   generate
      if (SAT_BASE) begin : g_sat
         assign dbase = d_diff[LOW_W] ? '0 : d_diff[LOW_W-1:0];
         assign tbase = t_diff[LOW_W] ? '0 : t_diff[LOW_W-1:0];
      end else begin : g_wrap
         logic unused_borrow;
         assign unused_borrow = d_diff[LOW_W] ^ t_diff[LOW_W];
         assign dbase = d_diff[LOW_W-1:0];
         assign tbase = t_diff[LOW_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/dtd_classify.sv
module dtd_classify
   import dtd_pkg::*;
#(
   parameter int PA_W   = 39,
   parameter bit REG_IN = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_vld,
   input  logic [PA_W-1:0]        req_pa,
   input  logic [LOW_W-1:0]       low_top,
   input  logic [PA_W-MB_LSB-1:0] up_top,
   input  logic [LOW_W-1:0]       dbase,
   input  logic [LOW_W-1:0]       tbase,
   output logic                   rsp_vld,
   output region_e                rsp_region
);
   localparam int HI_W = PA_W - MB_LSB;

   logic            vld_q;
   logic [PA_W-1:0] pa_q;

   generate
      if (REG_IN) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld_q <= 1'b0;
               pa_q  <= '0;
            end else begin
               vld_q <= req_vld;
               if (req_vld) pa_q <= req_pa;
            end
         end
      end else begin : g_pass
         assign vld_q = req_vld;
         assign pa_q  = req_pa;
      end
   endgenerate

   logic             below4g;
   logic [LOW_W-1:0] lo_mb;
   logic [HI_W-1:0]  hi_mb;

   assign below4g = ~|pa_q[PA_W-1:32];
   assign lo_mb   = pa_q[31:MB_LSB];
   assign hi_mb   = pa_q[PA_W-1:MB_LSB];

   always_comb begin
      rsp_region = RGN_NONE;
      if (below4g) begin
         if (lo_mb < low_top) begin
            if (lo_mb >= dbase)      rsp_region = RGN_GDATA;
            else if (lo_mb >= tbase) rsp_region = RGN_TABLE;
            else                     rsp_region = RGN_LOW;
         end
      end else if (hi_mb < up_top) begin
         rsp_region = RGN_HIGH;
      end
   end

   assign rsp_vld = vld_q;

   logic unused_pa;
   assign unused_pa = ^pa_q[MB_LSB-1:0];

endmodule

// File: rtl/dram_top_decoder.sv
module dram_top_decoder
   import dtd_pkg::*;
#(
   parameter int PA_W     = 39,
   parameter bit REG_IN   = 1'b1,
   parameter bit SAT_BASE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_wr,
   input  logic [1:0]      cfg_addr,
   input  logic [31:0]     cfg_wdata,
   output logic [31:0]     cfg_rdata,
   input  logic            req_vld,
   input  logic [PA_W-1:0] req_pa,
   output logic            rsp_vld,
   output logic [2:0]      rsp_region
);
   localparam int UP_W = PA_W - MB_LSB;

   generate
      if (PA_W <= 32 || PA_W > 51) begin : g_bad_pa_w
         $error("dram_top_decoder: PA_W must lie in 33..51");
      end
   endgenerate

   logic [LOW_W-1:0] low_top, dbase, tbase;
   logic             low_lock, up_lock, g_lock, rsvd, cfg_err;
   logic [UP_W-1:0]  up_top;
   logic [7:0]       dcode;
   logic [1:0]       tcode;
   region_e          region;

   dtd_cfg_regs #(.UP_W(UP_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .addr(cfg_addr),
      .wdata(cfg_wdata), .rdata(cfg_rdata), .cfg_err(cfg_err),
      .low_top(low_top), .low_lock(low_lock), .up_top(up_top),
      .up_lock(up_lock), .dcode(dcode), .tcode(tcode), .g_lock(g_lock)
   );

   dtd_base_calc #(.SAT_BASE(SAT_BASE)) u_base (
      .low_top(low_top), .dcode(dcode), .tcode(tcode),
      .dbase(dbase), .tbase(tbase), .rsvd(rsvd)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) cfg_err <= 1'b0;
      else if (rsvd) cfg_err <= 1'b1;
   end

   dtd_classify #(.PA_W(PA_W), .REG_IN(REG_IN)) u_cls (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_pa(req_pa),
      .low_top(low_top), .up_top(up_top), .dbase(dbase), .tbase(tbase),
      .rsp_vld(rsp_vld), .rsp_region(region)
   );

   assign rsp_region = region;

endmodule

// File: rtl/dtd_chk.sv
module dtd_chk #(
   parameter int LOW_W    = 12,
   parameter int UP_W     = 19,
   parameter bit REG_IN   = 1'b1,
   parameter bit SAT_BASE = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_vld,
   input logic             rsp_vld,
   input logic [LOW_W-1:0] low_top,
   input logic             low_lock,
   input logic [UP_W-1:0]  up_top,
   input logic             up_lock,
   input logic [7:0]       dcode,
   input logic [1:0]       tcode,
   input logic             g_lock,
   input logic [LOW_W-1:0] dbase,
   input logic [LOW_W-1:0] tbase,
   input logic             cfg_err
);
   // R4: a locked low boundary never changes again
   assert_low_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
      low_lock |=> (low_lock && $stable(low_top)));

   // R4: a locked upper boundary never changes again
   assert_up_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
      up_lock |=> (up_lock && $stable(up_top)));

   // R8: a locked control word freezes both size codes
   assert_gctl_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
      g_lock |=> (g_lock && $stable(dcode) && $stable(tcode)));

   // R9: the error flag is sticky
   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> cfg_err);

   generate
      if (REG_IN) begin : g_lat
         // R10: each request yields a result on the next cycle, and only then
         assert_rsp_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
            req_vld |=> rsp_vld);
         assert_no_spurious_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !req_vld |=> !rsp_vld);
      end
      if (SAT_BASE) begin : g_order
         // R7, R12: the stacked bases stay ordered under the low boundary
         assert_base_order_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (tbase <= dbase) && (dbase <= low_top));
      end
   endgenerate

endmodule

bind dram_top_decoder dtd_chk #(
   .LOW_W(dtd_pkg::LOW_W), .UP_W(PA_W - dtd_pkg::MB_LSB),
   .REG_IN(REG_IN), .SAT_BASE(SAT_BASE)
) i_chk (
   .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .rsp_vld(rsp_vld),
   .low_top(low_top), .low_lock(low_lock), .up_top(up_top), .up_lock(up_lock),
   .dcode(dcode), .tcode(tcode), .g_lock(g_lock), .dbase(dbase),
   .tbase(tbase), .cfg_err(cfg_err)
);

// File: tb/test_dram_top_decoder.sv
module test_dram_top_decoder;
   localparam int PA_W = 39;
   localparam int NONE = 0, LOW = 1, HIGH = 2, GDATA = 3, TBL = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_wr = 1'b0;
   logic [1:0]      cfg_addr = '0;
   logic [31:0]     cfg_wdata = '0;
   logic [31:0]     cfg_rdata;
   logic            req_vld = 1'b0;
   logic [PA_W-1:0] req_pa = '0;
   logic            rsp_vld;
   logic [2:0]      rsp_region;

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done = 1'b0;
   int    exp_q[$];
   string tag_q[$];

   always #10 clk = ~clk;

   dram_top_decoder i_dram_top_decoder (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_vld(req_vld),
      .req_pa(req_pa), .rsp_vld(rsp_vld), .rsp_region(rsp_region)
   );

   task automatic send(input logic [PA_W-1:0] pa, input int exp, input string tag);
      @(negedge clk);
      req_vld = 1'b1;
      req_pa  = pa;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      req_vld = 1'b0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      cfg_addr = a;
      #1;
      n_cmp++;
      if (cfg_rdata !== exp) begin
         n_bad++;
         $display("FAIL %s: word %0d read %h expected %h", tag, a, cfg_rdata, exp);
      end
   endtask

   // monitor: compares each result against the scoreboard queue
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (rst_n && rsp_vld) begin
            if (exp_q.size() == 0) begin
               n_cmp++; n_bad++;
               $display("FAIL R10: rsp_vld=1 with no request outstanding, expected 0");
            end else begin
               int    e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               n_cmp++;
               if (int'(rsp_region) != e) begin
                  n_bad++;
                  $display("FAIL %s: region=%0d expected=%0d", t, rsp_region, e);
               end
            end
         end
      end
   end

   initial begin
      #(20 * 20000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1, R11: reset values and field positions
      rd(2'd0, 32'h0010_0000, "R1 low reset");
      rd(2'd1, 32'h0000_0000, "R1 upper reset");
      rd(2'd2, 32'h0000_0500, "R1 gctl reset");
      rd(2'd3, 32'h0000_0000, "R1 err reset");

      // 2 GB low top, 6 GB upper top, 160 MB data, 2 MB table
      wr(2'd0, 32'h8000_0000);
      wr(2'd1, 32'h0300_0000);
      wr(2'd2, 32'h0000_0540);
      rd(2'd1, 32'h0300_0000, "R11 upper readback");
      rd(2'd2, 32'h0000_0540, "R11 gctl readback");
      send(39'h0_0000_0000, LOW,   "R2 address zero");
      send(39'h0_75DF_FFFF, LOW,   "R2 just under table base");
      send(39'h0_75E0_0000, TBL,   "R7 table base");
      send(39'h0_75F0_0000, TBL,   "R6 table top MB");
      send(39'h0_7600_0000, GDATA, "R5 data base 1888 MB");
      send(39'h0_7FFF_FFFF, GDATA, "R7 last byte below top");
      send(39'h0_8000_0000, NONE,  "R2 at low top");
      send(39'h0_FFFF_FFFF, NONE,  "R2 below 4 GB above top");
      send(39'h1_0000_0000, HIGH,  "R3 at 4 GB");
      send(39'h1_7FFF_FFFF, HIGH,  "R3 below upper top");
      send(39'h1_8000_0000, NONE,  "R3 at upper top");
      send(39'h7F_FFFF_FFFF, NONE, "R3 top of space");

      // R5, R6: 512 MB data, 8 MB table
      wr(2'd2, 32'h0000_10C0);
      send(39'h0_6000_0000, GDATA, "R5 code 0x10 base");
      send(39'h0_5FFF_FFFF, TBL,   "R6 code 3 top");
      send(39'h0_5F80_0000, TBL,   "R6 code 3 base");
      send(39'h0_5F7F_FFFF, LOW,   "R6 code 3 below");
      // 2016 MB data, 4 MB table
      wr(2'd2, 32'h0000_3F80);
      send(39'h0_0200_0000, GDATA, "R5 code 0x3F base");
      send(39'h0_01FF_FFFF, TBL,   "R6 code 2 top");
      send(39'h0_01C0_0000, TBL,   "R6 code 2 base");
      send(39'h0_01BF_FFFF, LOW,   "R6 code 2 below");
      // 1024 MB data, no table
      wr(2'd2, 32'h0000_2000);
      send(39'h0_4000_0000, GDATA, "R5 code 0x20 base");
      send(39'h0_3FFF_FFFF, LOW,   "R6 code 0 no table");
      // 1536 MB data
      wr(2'd2, 32'h0000_3000);
      send(39'h0_2000_0000, GDATA, "R5 code 0x30 base");
      send(39'h0_1FFF_FFFF, LOW,   "R5 code 0x30 below");
      // 0 MB data
      wr(2'd2, 32'h0000_0000);
      send(39'h0_7FFF_FFFF, LOW,   "R5 code 0x00 empty");
      rd(2'd3, 32'h0000_0000, "R9 no error on listed codes");

      // R9: reserved code
      wr(2'd2, 32'h0000_1100);
      send(39'h0_7FFF_FFFF, LOW,   "R9 reserved code is zero size");
      rd(2'd3, 32'h0000_0001, "R9 error set");
      wr(2'd2, 32'h0000_0500);
      rd(2'd3, 32'h0000_0001, "R9 error sticky");
      send(39'h0_7FFF_FFFF, GDATA, "R9 corrected code works");

      // R12: 2016 MB under a 256 MB top clamps to zero
      wr(2'd2, 32'h0000_3F40);
      wr(2'd0, 32'h1000_0000);
      send(39'h0_0000_0000, GDATA, "R12 clamped base at zero");
      send(39'h0_0FFF_FFFF, GDATA, "R12 clamped top");
      send(39'h0_1000_0000, NONE,  "R12 above top");

      // R4: boundary locks
      wr(2'd0, 32'h8000_0001);
      rd(2'd0, 32'h8000_0001, "R4 low locked readback");
      wr(2'd0, 32'h4000_0000);
      rd(2'd0, 32'h8000_0001, "R4 low write ignored");
      send(39'h0_7FFF_FFFF, GDATA, "R4 low top unchanged");
      send(39'h0_9000_0000, NONE,  "R4 low top unchanged above");
      wr(2'd1, 32'h0300_0001);
      wr(2'd1, 32'h0100_0000);
      rd(2'd1, 32'h0300_0001, "R4 upper write ignored");
      send(39'h1_7FFF_FFFF, HIGH,  "R4 upper top unchanged");

      // R8: control lock
      wr(2'd2, 32'h0000_0541);
      wr(2'd2, 32'h0000_1000);
      rd(2'd2, 32'h0000_0541, "R8 gctl write ignored");
      send(39'h0_75F0_0000, TBL,   "R8 codes unchanged");
      rd(2'd3, 32'h0000_0001, "R11 status word");

      // R10: no result without a request
      repeat (3) @(negedge clk);
      @(posedge clk);
      #2;
      n_cmp++;
      if (rsp_vld !== 1'b0 || exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL R10: idle rsp_vld=%0b pending=%0d expected 0/0", rsp_vld, exp_q.size());
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule